// File: doc/BRIEF.md
# Signed integer to single-precision converter with vector merge

The block takes a signed two's-complement integer, either 32 or 64 bits wide, and turns it into an IEEE-754 single-precision number. The result goes into the low 32 bits of a 256-bit vector destination value. The bits above it are filled by one of two rules picked by a form select. The legacy form keeps the old destination contents. The VEX form copies bits 127:32 from a 128-bit first-source vector and clears bits 255:128.

An inexact result is rounded using a 2-bit rounding-control input. A precision flag reports whenever rounding discarded any nonzero bits. The block sits in an execution pipeline and has a one-cycle registered valid path.

Sequencing is handled by a two-state machine:
- ST_IDLE means no result is being presented.
- ST_EMIT means the registered result is valid this cycle.

The transitions are:
- IDLE→EMIT and EMIT→EMIT both occur on an accepted input.
- EMIT→IDLE and IDLE→IDLE both occur when no input is offered.

The result registers load only on an accepted input and hold their value otherwise.

Top module: `int_to_sp_cvt`

## Requirements
- R1: All 64 source bits are used only when `mode64` and `opsize64` are both 1. In every other case `src_int[31:0]` is taken as a signed 32-bit value and `src_int[63:32]` has no effect. In particular, `opsize64` = 1 with `mode64` = 0 gives a 32-bit conversion.
- R2: `dest_new[31:0]` holds the single-precision encoding: sign in bit 31, biased exponent (bias 127) in bits 30:23, and fraction in bits 22:0. The most negative integers convert exactly: −2^31 gives 0xCF000000 and −2^63 gives 0xDF000000.
- R3: `round_ctl` selects the rounding direction for an inexact result:
  - 00 rounds to nearest, with ties going to the even fraction.
  - 01 rounds toward −∞.
  - 10 rounds toward +∞.
  - 11 rounds toward zero.
- R4: `inexact` is 1 exactly when the conversion discarded nonzero bits. Any integer whose magnitude is below 2^24 converts exactly, with `inexact` = 0.
- R5: An input of zero produces 0x00000000 (+0.0) with `inexact` = 0, in every rounding mode.
- R6: When `vex_form` = 0, `dest_new[255:32]` equals `dest_old[255:32]` as sampled with the input.
- R7: When `vex_form` = 1, `dest_new[127:32]` equals `vec_src1[127:32]` and `dest_new[255:128]` is zero.
- R8: `out_valid` is 1 in exactly the cycle after each cycle in which `in_valid` is 1. Back-to-back inputs give back-to-back results.
- R9: While `in_valid` is 0, `dest_new` and `inexact` keep the last result, whatever the other inputs do.
- R10: A rounding carry out of the significand raises the exponent by one. For example, 0x7FFFFFFF rounded to nearest gives 0x4F000000.
- R11: After reset, `out_valid`, `inexact` and `dest_new` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands valid this cycle |
| src_int | input | 64 | Signed integer source |
| mode64 | input | 1 | Core is in 64-bit mode |
| opsize64 | input | 1 | 64-bit operand size requested |
| round_ctl | input | 2 | Rounding direction (see R3) |
| vex_form | input | 1 | 1 selects the VEX upper-bit rule, 0 selects legacy |
| vec_src1 | input | 128 | First-source vector for the VEX form |
| dest_old | input | 256 | Previous destination contents |
| out_valid | output | 1 | Result valid |
| dest_new | output | 256 | Merged destination value |
| inexact | output | 1 | Precision flag |

## Verification
The converter is driven with several kinds of input, each aimed at a different part of the logic:
- Zero, ±1 and both most-negative integers exercise the sign and magnitude path.
- Powers of two across the full wide range test the leading-zero count and exponent without any rounding.
- Exact halfway values with odd and even kept LSBs separate nearest-even from plain round-up and from the directed modes.
- Negative halfway values show that the directed modes act on the sign, not the magnitude.
- All-ones magnitudes force a carry out of the significand.

Random operands under random mode, size, rounding and form settings cover ordinary cases. Garbage in the upper source bits during 32-bit conversions catches a wrong width choice. Idle cycles with scrambled inputs show the hold behaviour.

// File: rtl/sicvt_pkg.sv
package sicvt_pkg;

    localparam int INT_W    = 64;
    localparam int NARROW_W = 32;
    localparam int MANT_W   = 23;
    localparam int EXP_W    = 8;
    localparam int EXP_BIAS = 127;
    localparam int FP_W     = 1 + EXP_W + MANT_W;
    localparam int VEC_W    = 256;
    localparam int SRC1_W   = 128;

    // Rounding-direction encoding carried on round_ctl
    typedef enum logic [1:0] {
        RC_NEAR_EVEN = 2'b00,
        RC_TO_NEG    = 2'b01,
        RC_TO_POS    = 2'b10,
        RC_TO_ZERO   = 2'b11
    } rmode_e;

    // Result sequencing states
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } seq_state_e;

endpackage

// File: rtl/sicvt_operand.sv
// Picks the operand width and splits it into sign and magnitude.
module sicvt_operand #(
    parameter int INT_W    = sicvt_pkg::INT_W,
    parameter int NARROW_W = sicvt_pkg::NARROW_W
) (
    input  logic [INT_W-1:0] src_int,
    input  logic             mode64,
    input  logic             opsize64,
    output logic             neg,
    output logic [INT_W-1:0] mag
);
    localparam int               EXT_W = INT_W - NARROW_W;
    localparam logic [INT_W-1:0] ONE   = INT_W'(1);

    logic             wide_sel;
    logic [INT_W-1:0] value;

    always_comb begin
        // the wide size only counts when the core runs in 64-bit mode
        wide_sel = mode64 & opsize64;
        if (wide_sel) begin
            value = src_int;
        end else begin
            value = {{EXT_W{src_int[NARROW_W-1]}}, src_int[NARROW_W-1:0]};
        end
        neg = value[INT_W-1];
        // the most negative value maps to 2^(INT_W-1), still representable unsigned
        mag = neg ? (~value + ONE) : value;
    end

endmodule

// File: rtl/sicvt_normalize.sv
// Leading-zero count, left alignment and exponent of the magnitude.
module sicvt_normalize #(
    parameter int INT_W    = sicvt_pkg::INT_W,
    parameter int EXP_W    = sicvt_pkg::EXP_W,
    parameter int EXP_BIAS = sicvt_pkg::EXP_BIAS
) (
    input  logic [INT_W-1:0] mag,
    output logic [INT_W-1:0] norm,
    output logic [EXP_W-1:0] exp_biased
);
    localparam int LZ_W    = $clog2(INT_W + 1);
    localparam int TOP_EXP = EXP_BIAS + INT_W - 1;

    logic [LZ_W-1:0] lz;

    // priority scan: the highest set bit wins because it is visited last
    always_comb begin
        lz = LZ_W'(INT_W);
        for (int i = 0; i < INT_W; i++) begin
            if (mag[i]) begin
                lz = LZ_W'(INT_W - 1 - i);
            end
        end
    end

    always_comb begin
        norm       = mag << lz;
        exp_biased = EXP_W'(TOP_EXP) - EXP_W'(lz);
    end

endmodule

// File: rtl/sicvt_round.sv
// Rounds the aligned magnitude to a single-precision significand.
module sicvt_round #(
    parameter int INT_W  = sicvt_pkg::INT_W,
    parameter int MANT_W = sicvt_pkg::MANT_W,
    parameter int EXP_W  = sicvt_pkg::EXP_W,
    parameter int FP_W   = sicvt_pkg::FP_W
) (
    input  logic             neg,
    input  logic [INT_W-1:0] norm,
    input  logic [EXP_W-1:0] exp_in,
    input  logic [1:0]       round_ctl,
    output logic [FP_W-1:0]  fp,
    output logic             inexact
);
    import sicvt_pkg::*;

    localparam int LSB_POS = INT_W - 1 - MANT_W;
    localparam int GRD_POS = LSB_POS - 1;

    logic              lead;
    logic [MANT_W-1:0] frac;
    logic              lsb_bit;
    logic              guard;
    logic              sticky;
    logic              lost;
    logic              up;
    logic [MANT_W:0]   sum;
    logic [EXP_W-1:0]  exp_out;

    always_comb begin
        lead    = norm[INT_W-1];
        frac    = norm[INT_W-2 -: MANT_W];
        lsb_bit = norm[LSB_POS];
        guard   = norm[GRD_POS];
        sticky  = |norm[GRD_POS-1:0];
        lost    = guard | sticky;

        unique case (rmode_e'(round_ctl))
            RC_NEAR_EVEN: up = guard & (sticky | lsb_bit);
            RC_TO_NEG:    up = neg & lost;
            RC_TO_POS:    up = ~neg & lost;
            RC_TO_ZERO:   up = 1'b0;
            default:      up = 1'b0;
        endcase

        sum     = {1'b0, frac} + (MANT_W+1)'(up);
        // a carry leaves the fraction at zero and bumps the exponent
        exp_out = exp_in + EXP_W'(sum[MANT_W]);

        if (!lead) begin
            fp      = '0;
            inexact = 1'b0;
        end else begin
            fp      = {neg, exp_out, sum[MANT_W-1:0]};
            inexact = lost;
        end
    end

endmodule

// File: rtl/sicvt_merge.sv
// Places the scalar result into the wide destination.
module sicvt_merge #(
    parameter int VEC_W  = sicvt_pkg::VEC_W,
    parameter int SRC1_W = sicvt_pkg::SRC1_W,
    parameter int FP_W   = sicvt_pkg::FP_W
) (
    input  logic [VEC_W-1:0]  dest_old,
    input  logic [SRC1_W-1:0] vec_src1,
    input  logic              vex_form,
    input  logic [FP_W-1:0]   fp,
    output logic [VEC_W-1:0]  dest_new
);
    localparam int ZERO_W = VEC_W - SRC1_W;

    always_comb begin
        if (vex_form) begin
            dest_new = {{ZERO_W{1'b0}}, vec_src1};
        end else begin
            dest_new = dest_old;
        end
        dest_new[FP_W-1:0] = fp;
    end

endmodule

// File: rtl/int_to_sp_cvt.sv
module int_to_sp_cvt #(
    parameter int INT_W    = sicvt_pkg::INT_W,
    parameter int NARROW_W = sicvt_pkg::NARROW_W,
    parameter int VEC_W    = sicvt_pkg::VEC_W,
    parameter int SRC1_W   = sicvt_pkg::SRC1_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [INT_W-1:0]  src_int,
    input  logic              mode64,
    input  logic              opsize64,
    input  logic [1:0]        round_ctl,
    input  logic              vex_form,
    input  logic [SRC1_W-1:0] vec_src1,
    input  logic [VEC_W-1:0]  dest_old,
    output logic              out_valid,
    output logic [VEC_W-1:0]  dest_new,
    output logic              inexact
);
    import sicvt_pkg::*;

    localparam int MANT_W = sicvt_pkg::MANT_W;
    localparam int EXP_W  = sicvt_pkg::EXP_W;
    localparam int FP_W   = 1 + EXP_W + MANT_W;

    seq_state_e       state;
    seq_state_e       state_nx;
    logic             op_neg;
    logic [INT_W-1:0] op_mag;
    logic [INT_W-1:0] op_norm;
    logic [EXP_W-1:0] op_exp;
    logic [FP_W-1:0]  fp_res;
    logic             fp_inexact;
    logic [VEC_W-1:0] merged;
    logic [VEC_W-1:0] dest_q;
    logic             inexact_q;

    sicvt_operand #(
        .INT_W    (INT_W),
        .NARROW_W (NARROW_W)
    ) u_operand (
        .src_int  (src_int),
        .mode64   (mode64),
        .opsize64 (opsize64),
        .neg      (op_neg),
        .mag      (op_mag)
    );

    sicvt_normalize #(
        .INT_W      (INT_W),
        .EXP_W      (EXP_W),
        .EXP_BIAS   (sicvt_pkg::EXP_BIAS)
    ) u_normalize (
        .mag        (op_mag),
        .norm       (op_norm),
        .exp_biased (op_exp)
    );

    sicvt_round #(
        .INT_W     (INT_W),
        .MANT_W    (MANT_W),
        .EXP_W     (EXP_W),
        .FP_W      (FP_W)
    ) u_round (
        .neg       (op_neg),
        .norm      (op_norm),
        .exp_in    (op_exp),
        .round_ctl (round_ctl),
        .fp        (fp_res),
        .inexact   (fp_inexact)
    );

    sicvt_merge #(
        .VEC_W    (VEC_W),
        .SRC1_W   (SRC1_W),
        .FP_W     (FP_W)
    ) u_merge (
        .dest_old (dest_old),
        .vec_src1 (vec_src1),
        .vex_form (vex_form),
        .fp       (fp_res),
        .dest_new (merged)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        unique case (state)
            ST_IDLE: state_nx = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_nx = in_valid ? ST_EMIT : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // output registers: load on an accepted input, otherwise hold
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dest_q    <= '0;
            inexact_q <= 1'b0;
        end else if (in_valid) begin
            dest_q    <= merged;
            inexact_q <= fp_inexact;
        end
    end

    assign out_valid = (state == ST_EMIT);
    assign dest_new  = dest_q;
    assign inexact   = inexact_q;

endmodule

// File: rtl/int_to_sp_cvt_chk.sv
module int_to_sp_cvt_chk #(
    parameter int INT_W    = 64,
    parameter int NARROW_W = 32,
    parameter int VEC_W    = 256,
    parameter int SRC1_W   = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [INT_W-1:0]  src_int,
    input logic              mode64,
    input logic              opsize64,
    input logic              vex_form,
    input logic [SRC1_W-1:0] vec_src1,
    input logic [VEC_W-1:0]  dest_old,
    input logic              out_valid,
    input logic [VEC_W-1:0]  dest_new,
    input logic              inexact
);
    localparam int SMALL_W = 24;

    // R8: a result appears one cycle after each accepted input
    p_valid_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R8: no result without an input the cycle before
    p_valid_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R9: result registers hold while idle
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(dest_new) && $stable(inexact)));

    // R6: legacy form keeps the old upper bits
    p_legacy_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !vex_form) |=> (dest_new[VEC_W-1:32] == $past(dest_old[VEC_W-1:32])));

    // R7: VEX form copies the first source and clears the top half
    p_vex_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && vex_form) |=> ((dest_new[SRC1_W-1:32] == $past(vec_src1[SRC1_W-1:32]))
                                    && (dest_new[VEC_W-1:SRC1_W] == '0)));

    // R5: zero converts to +0.0 exactly
    p_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (src_int == '0)) |=> ((dest_new[31:0] == 32'h0) && !inexact));

    // R4: narrow operands with small nonnegative values are exact
    p_small_exact_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !(mode64 && opsize64) && (src_int[NARROW_W-1:SMALL_W] == '0)) |=> !inexact);

    // R2: sign bit follows the narrow operand sign for nonzero values
    p_sign_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mode64 && (src_int[NARROW_W-1:0] != '0)) |=> (dest_new[31] == $past(src_int[NARROW_W-1])));

endmodule

bind int_to_sp_cvt int_to_sp_cvt_chk #(
    .INT_W    (INT_W),
    .NARROW_W (NARROW_W),
    .VEC_W    (VEC_W),
    .SRC1_W   (SRC1_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .src_int   (src_int),
    .mode64    (mode64),
    .opsize64  (opsize64),
    .vex_form  (vex_form),
    .vec_src1  (vec_src1),
    .dest_old  (dest_old),
    .out_valid (out_valid),
    .dest_new  (dest_new),
    .inexact   (inexact)
);

// File: tb/tb_int_to_sp_cvt.sv
`timescale 1ns/1ps
module tb_int_to_sp_cvt;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [63:0]  src_int = '0;
    logic         mode64 = 1'b0;
    logic         opsize64 = 1'b0;
    logic [1:0]   round_ctl = 2'b00;
    logic         vex_form = 1'b0;
    logic [127:0] vec_src1 = '0;
    logic [255:0] dest_old = '0;
    logic         out_valid;
    logic [255:0] dest_new;
    logic         inexact;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    logic [255:0] q_dest[$];
    logic         q_inx[$];
    string        q_tag[$];
    logic [255:0] last_dest = '0;
    logic         last_inx = 1'b0;

    always #2.5 clk = ~clk;

    int_to_sp_cvt dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .src_int   (src_int),
        .mode64    (mode64),
        .opsize64  (opsize64),
        .round_ctl (round_ctl),
        .vex_form  (vex_form),
        .vec_src1  (vec_src1),
        .dest_old  (dest_old),
        .out_valid (out_valid),
        .dest_new  (dest_new),
        .inexact   (inexact)
    );

    // behavioural model: {inexact, single bits}
    function automatic logic [32:0] ref_cvt(input logic [63:0] s, input logic m64,
                                            input logic op64, input logic [1:0] rc);
        logic [63:0] v, mag, q, rem, half;
        logic        neg, up, inx;
        int          msb, sh, e;
        v   = (m64 && op64) ? s : {{32{s[31]}}, s[31:0]};
        neg = v[63];
        mag = neg ? (64'd0 - v) : v;
        if (mag == 64'd0) return 33'd0;
        msb = 0;
        for (int i = 0; i < 64; i++) if (mag[i]) msb = i;
        e = 127 + msb;
        if (msb <= 23) begin
            q   = mag << (23 - msb);
            inx = 1'b0;
        end else begin
            sh   = msb - 23;
            q    = mag >> sh;
            rem  = mag - (q << sh);
            half = 64'd1 << (sh - 1);
            inx  = (rem != 64'd0);
            case (rc)
                2'b00:   up = (rem > half) || ((rem == half) && q[0]);
                2'b01:   up = neg && inx;
                2'b10:   up = !neg && inx;
                default: up = 1'b0;
            endcase
            q = q + {63'd0, up};
            if (q[24]) begin
                q = q >> 1;
                e = e + 1;
            end
        end
        return {inx, neg, e[7:0], q[22:0]};
    endfunction

    function automatic logic [255:0] ref_merge(input logic [255:0] old, input logic [127:0] s1,
                                               input logic vex, input logic [31:0] fp);
        logic [255:0] r;
        r = vex ? {128'd0, s1} : old;
        r[31:0] = fp;
        return r;
    endfunction

    task automatic report_summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // driver: presents one operand set and queues the expected result
    task automatic send(input logic [63:0] s, input logic m64, input logic op64,
                        input logic [1:0] rc, input logic vex,
                        input logic [31:0] efp, input logic einx, input string tag);
        logic [127:0] s1;
        logic [255:0] old;
        logic [255:0] exp_dest;
        s1  = {$urandom, $urandom, $urandom, $urandom};
        old = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
        @(negedge clk);
        src_int   = s;
        mode64    = m64;
        opsize64  = op64;
        round_ctl = rc;
        vex_form  = vex;
        vec_src1  = s1;
        dest_old  = old;
        in_valid  = 1'b1;
        exp_dest  = ref_merge(old, s1, vex, efp);
        q_dest.push_back(exp_dest);
        q_inx.push_back(einx);
        q_tag.push_back(tag);
        last_dest = exp_dest;
        last_inx  = einx;
    endtask

    task automatic send_ref(input logic [63:0] s, input logic m64, input logic op64,
                            input logic [1:0] rc, input logic vex, input string tag);
        logic [32:0] r;
        r = ref_cvt(s, m64, op64, rc);
        send(s, m64, op64, rc, vex, r[31:0], r[32], tag);
    endtask

    // idle cycle with scrambled operands
    task automatic idle();
        @(negedge clk);
        in_valid  = 1'b0;
        src_int   = {$urandom, $urandom};
        mode64    = $urandom % 2;
        opsize64  = $urandom % 2;
        round_ctl = 2'($urandom);
        vex_form  = $urandom % 2;
        vec_src1  = {$urandom, $urandom, $urandom, $urandom};
        dest_old  = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    endtask

    // monitor: pops the scoreboard when a result is presented
    always @(posedge clk) begin
        #1;
        if (rst_n && out_valid) begin
            if (q_dest.size() == 0) begin
                n_tests++;
                n_fail++;
                $display("FAIL R8 unexpected out_valid: got 1 expected 0");
            end else begin
                logic [255:0] ed;
                logic         ei;
                string        t;
                ed = q_dest.pop_front();
                ei = q_inx.pop_front();
                t  = q_tag.pop_front();
                n_tests++;
                if (dest_new !== ed || inexact !== ei) begin
                    n_fail++;
                    $display("FAIL %s: got dest=%h inx=%b expected dest=%h inx=%b",
                             t, dest_new, inexact, ed, ei);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R8 watchdog expired: got no completion expected completion");
        report_summary();
    end

    initial begin
        // R11 reset state
        repeat (3) @(negedge clk);
        n_tests++;
        if (out_valid !== 1'b0 || inexact !== 1'b0 || dest_new !== '0) begin
            n_fail++;
            $display("FAIL R11 reset: got valid=%b inx=%b dest=%h expected 0 0 0",
                     out_valid, inexact, dest_new);
        end
        rst_n = 1'b1;
        idle();

        // directed values, issued back to back
        send(64'd0, 1'b1, 1'b1, 2'b10, 1'b0, 32'h00000000, 1'b0, "R5 zero up");
        send(64'd0, 1'b0, 1'b0, 2'b01, 1'b1, 32'h00000000, 1'b0, "R5 zero down");
        send(64'd1, 1'b0, 1'b0, 2'b00, 1'b0, 32'h3F800000, 1'b0, "R2 one");
        send(64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b1, 2'b00, 1'b1, 32'hBF800000, 1'b0, "R2 minus one wide");
        send(64'h0000_0000_8000_0000, 1'b0, 1'b0, 2'b00, 1'b0, 32'hCF000000, 1'b0, "R2 min narrow");
        send(64'h8000_0000_0000_0000, 1'b1, 1'b1, 2'b00, 1'b1, 32'hDF000000, 1'b0, "R2 min wide");
        send(64'hFFFF_FFFF_0000_0005, 1'b0, 1'b1, 2'b00, 1'b0, 32'h40A00000, 1'b0, "R1 wide size outside mode");
        send(64'hFFFF_FFFF_0000_0005, 1'b1, 1'b0, 2'b00, 1'b1, 32'h40A00000, 1'b0, "R1 narrow size in mode");
        send(64'h0000_0001_0000_0000, 1'b1, 1'b1, 2'b00, 1'b0, 32'h4F800000, 1'b0, "R1 wide 2^32");
        send(64'h0100_0001, 1'b0, 1'b0, 2'b00, 1'b0, 32'h4B800000, 1'b1, "R3 tie even nearest");
        send(64'h0100_0001, 1'b0, 1'b0, 2'b10, 1'b0, 32'h4B800001, 1'b1, "R3 tie toward +inf");
        send(64'h0100_0001, 1'b0, 1'b0, 2'b01, 1'b1, 32'h4B800000, 1'b1, "R3 tie toward -inf");
        send(64'h0100_0001, 1'b0, 1'b0, 2'b11, 1'b0, 32'h4B800000, 1'b1, "R3 tie toward zero");
        send(64'h0100_0003, 1'b0, 1'b0, 2'b00, 1'b0, 32'h4B800002, 1'b1, "R3 tie odd nearest");
        send(64'hFEFF_FFFF, 1'b0, 1'b0, 2'b01, 1'b1, 32'hCB800001, 1'b1, "R3 negative toward -inf");
        send(64'hFEFF_FFFF, 1'b0, 1'b0, 2'b10, 1'b0, 32'hCB800000, 1'b1, "R3 negative toward +inf");
        send(64'h7FFF_FFFF, 1'b0, 1'b0, 2'b00, 1'b0, 32'h4F000000, 1'b1, "R10 carry narrow");
        send(64'h7FFF_FFFF, 1'b0, 1'b0, 2'b11, 1'b0, 32'h4EFFFFFF, 1'b1, "R3 truncate max narrow");
        send(64'h7FFF_FFFF_FFFF_FFFF, 1'b1, 1'b1, 2'b00, 1'b1, 32'h5F000000, 1'b1, "R10 carry wide");
        send(64'h00FF_FFFF, 1'b0, 1'b0, 2'b00, 1'b0, 32'h4B7FFFFF, 1'b0, "R4 largest exact");

        // R9: scrambled idle inputs must not disturb the held result
        repeat (3) idle();
        @(negedge clk);
        n_tests++;
        if (out_valid !== 1'b0 || dest_new !== last_dest || inexact !== last_inx) begin
            n_fail++;
            $display("FAIL R9 hold: got valid=%b dest=%h inx=%b expected valid=0 dest=%h inx=%b",
                     out_valid, dest_new, inexact, last_dest, last_inx);
        end

        // powers of two and their neighbours across the wide range (R2, R4)
        for (int i = 0; i < 63; i++) begin
            send_ref(64'd1 << i, 1'b1, 1'b1, 2'($urandom), 1'($urandom), "R2 wide power of two");
            send_ref((64'd1 << i) + 64'd1, 1'b1, 1'b1, 2'($urandom), 1'($urandom), "R4 power plus one");
            send_ref(64'd0 - (64'd1 << i), 1'b1, 1'b1, 2'($urandom), 1'($urandom), "R2 negative power");
        end
        idle();

        // random operands, random controls, occasional gaps (R1, R3, R4, R6, R7, R8)
        for (int k = 0; k < 600; k++) begin
            logic [63:0] v;
            v = {$urandom, $urandom} >> ($urandom % 64);
            if ($urandom % 2) v = 64'd0 - v;
            send_ref(v, 1'($urandom), 1'($urandom), 2'($urandom), 1'($urandom), "R3 random");
            if ($urandom % 4 == 0) idle();
        end
        idle();

        repeat (5) @(negedge clk);
        n_tests++;
        if (q_dest.size() != 0) begin
            n_fail++;
            $display("FAIL R8 missing results: got %0d pending expected 0", q_dest.size());
        end
        report_summary();
    end

endmodule